// File: doc/BRIEF.md
# Fixed-Point to Single-Precision Float Encoder

This block turns a signed two's-complement fixed-point number into a 32-bit single-precision floating-point word. The input carries `INT_W` integer bits and `FRAC_W` fractional bits, so its value is the raw integer divided by 2^FRAC_W. The encoder splits off the sign and turns a negative input into its magnitude. It then finds the leading one and shifts it up to the hidden-bit position. It keeps the 23 bits that follow it, rounds away the rest and biases the exponent.

Each conversion starts with a one-cycle `in_valid` pulse. The result appears two cycles later together with an `out_valid` pulse. A new conversion may start in every cycle. Between results, the output word keeps the last value.

A separate combinational classifier takes any 32-bit float word and reports its category from the reserved exponent codes. It does not depend on the conversion pipeline.

Top module: `fxf_encoder`

## Requirements
- R1: A nonzero input is encoded with bit 31 as the sign, bits 30..23 as the true exponent plus 127, and bits 22..0 as the bits below the leading one. The leading one itself is not stored. An input of 25.75 gives 0x41CE0000, 1.0 gives 0x3F800000 and 2^-16 gives 0x37800000.
- R2: A negative input sets bit 31 to 1, and the rest of the word equals the encoding of its absolute value. For example, -25.75 gives 0xC1CE0000.
- R3: The most negative input, -2^(INT_W-1), is encoded without overflow. With the default widths it gives 0xC7000000.
- R4: An input of zero gives the all-zero word 0x00000000. The encoder never produces a word whose exponent field is 0 and whose fraction is nonzero.
- R5: Bits below the 23 kept fraction bits are rounded to nearest, with ties to even. When rounding carries out of the fraction, the fraction becomes 0 and the exponent goes up by one. For example, 0x7FFFFFFF gives 0x47000000.
- R6: `out_valid` is high exactly two cycles after a cycle with `in_valid` high, and only then. Conversions may start in back-to-back cycles, and each one produces its own result in order.
- R7: While no result is being delivered, `out_word` keeps its previous value, and input changes have no effect on it.
- R8: `cls_kind` classifies `cls_word` with these codes: 0 for zero (exponent 0, fraction 0), 1 for denormal (exponent 0, fraction nonzero), 2 for normal, 3 for infinity (exponent 255, fraction 0) and 4 for NaN (exponent 255, fraction nonzero). The sign bit does not affect the code.
- R9: After reset, `out_valid` is 0 and `out_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Starts a conversion of `in_fix` |
| in_fix | input | INT_W+FRAC_W | Signed fixed-point input |
| out_valid | output | 1 | Marks the cycle in which `out_word` holds a new result |
| out_word | output | 32 | Encoded single-precision word |
| cls_word | input | 32 | Float word to be classified |
| cls_kind | output | 3 | Category code of `cls_word` |

## Verification
A wrong leading-one position or shift amount shows up on the port as an exponent that is off by the same amount, together with a shifted fraction, in the very cycle `out_valid` rises. The tie and carry vectors are there to catch a rounding fault: it shows as a fraction that is one unit too high or too low in its last place, or as an exponent that did not move after a carry. A stage-valid or enable fault breaks the two-cycle timing of `out_valid`, or lets `out_word` change between results. It is visible one cycle after the stimulus that exposes it.

// File: rtl/fxf_pkg.sv
package fxf_pkg;
    localparam int EXP_W   = 8;
    localparam int MAN_W   = 23;
    localparam int BIAS    = 127;
    localparam int EXP_TOP = 255;

    typedef enum logic [2:0] {
        FK_ZERO = 3'd0,
        FK_SUB  = 3'd1,
        FK_NORM = 3'd2,
        FK_INF  = 3'd3,
        FK_NAN  = 3'd4
    } fkind_e;
endpackage

// File: rtl/fxf_lead_one.sv
module fxf_lead_one #(
    parameter int W  = 32,
    localparam int PW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [PW-1:0] pos,
    output logic          found
);
    // Highest set bit wins because later iterations overwrite earlier ones.
    always_comb begin
        pos   = '0;
        found = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                pos   = PW'(i);
                found = 1'b1;
            end
        end
    end
endmodule

// File: rtl/fxf_round_pack.sv
module fxf_round_pack
    import fxf_pkg::*;
#(
    parameter int W      = 32,
    parameter int FRAC_W = 16,
    localparam int PW    = $clog2(W),
    localparam int TW    = W - 1
) (
    input  logic          neg,
    input  logic          found,
    input  logic [PW-1:0] pos,
    input  logic [TW-1:0] tail,   // bits below the normalised leading one
    output logic [31:0]   word
);
    logic [MAN_W-1:0] frac_raw;
    logic             guard;
    logic             sticky;

    // The width of the tail relative to the kept fraction picks the variant.
    generate
        if (TW > MAN_W + 1) begin : g_wide
            assign frac_raw = tail[TW-1 -: MAN_W];
            assign guard    = tail[TW-1-MAN_W];
            assign sticky   = |tail[TW-2-MAN_W:0];
        end else if (TW == MAN_W + 1) begin : g_guard_only
            assign frac_raw = tail[TW-1 -: MAN_W];
            assign guard    = tail[0];
            assign sticky   = 1'b0;
        end else if (TW == MAN_W) begin : g_exact
            assign frac_raw = tail;
            assign guard    = 1'b0;
            assign sticky   = 1'b0;
        end else begin : g_narrow
            assign frac_raw = {tail, {(MAN_W-TW){1'b0}}};
            assign guard    = 1'b0;
            assign sticky   = 1'b0;
        end
    endgenerate

    logic             inc;
    logic [MAN_W:0]   sum;
    int               e_biased;

    always_comb begin
        inc      = guard & (sticky | frac_raw[0]);
        sum      = {1'b0, frac_raw} + {{MAN_W{1'b0}}, inc};
        e_biased = int'(pos) - FRAC_W + BIAS + int'(sum[MAN_W]);
        if (!found) begin
            word = '0;
        end else if (e_biased >= EXP_TOP) begin
            word = {neg, {EXP_W{1'b1}}, {MAN_W{1'b0}}};
        end else if (e_biased < 1) begin
            word = {neg, {(EXP_W+MAN_W){1'b0}}};
        end else begin
            word = {neg, e_biased[EXP_W-1:0], sum[MAN_W-1:0]};
        end
    end
endmodule

// File: rtl/fxf_classify.sv
module fxf_classify
    import fxf_pkg::*;
(
    input  logic [31:0] word,
    output fkind_e      kind
);
    logic exp_zero;
    logic exp_full;
    logic man_zero;

    always_comb begin
        exp_zero = (word[30:23] == '0);
        exp_full = (word[30:23] == '1);
        man_zero = (word[22:0] == '0);
        if (exp_full)      kind = man_zero ? FK_INF  : FK_NAN;
        else if (exp_zero) kind = man_zero ? FK_ZERO : FK_SUB;
        else               kind = FK_NORM;
    end
endmodule

// File: rtl/fxf_encoder.sv
module fxf_encoder
    import fxf_pkg::*;
#(
    parameter int INT_W  = 16,
    parameter int FRAC_W = 16,
    localparam int W     = INT_W + FRAC_W,
    localparam int PW    = $clog2(W),
    localparam int TW    = W - 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [W-1:0]  in_fix,
    output logic          out_valid,
    output logic [31:0]   out_word,
    input  logic [31:0]   cls_word,
    output logic [2:0]    cls_kind
);
    typedef struct packed {
        logic         valid;
        logic         neg;
        logic [W-1:0] mag;
    } st1_t;

    typedef struct packed {
        logic        valid;
        logic [31:0] word;
    } st2_t;

    st1_t s1_d, s1_q;
    st2_t s2_d, s2_q;

    logic [PW-1:0] lead_pos;
    logic          lead_found;
    logic [PW-1:0] shamt;
    logic [TW-1:0] tail;
    logic [31:0]   packed_word;
    fkind_e        kind;

    fxf_lead_one #(.W(W)) u_lead (
        .vec   (s1_q.mag),
        .pos   (lead_pos),
        .found (lead_found)
    );

    fxf_round_pack #(.W(W), .FRAC_W(FRAC_W)) u_pack (
        .neg   (s1_q.neg),
        .found (lead_found),
        .pos   (lead_pos),
        .tail  (tail),
        .word  (packed_word)
    );

    fxf_classify u_cls (
        .word (cls_word),
        .kind (kind)
    );

    always_comb begin
        // Stage 1: sign and magnitude; unsigned W bits hold 2^(W-1).
        s1_d.valid = in_valid;
        s1_d.neg   = in_fix[W-1];
        s1_d.mag   = in_fix[W-1] ? (~in_fix + W'(1)) : in_fix;

        // Stage 2: normalise, round, pack; hold word between results.
        shamt = PW'(W-1) - lead_pos;
        tail  = TW'(s1_q.mag << shamt);
        s2_d       = s2_q;
        s2_d.valid = s1_q.valid;
        if (s1_q.valid) s2_d.word = packed_word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    assign out_valid = s2_q.valid;
    assign out_word  = s2_q.word;
    assign cls_kind  = kind;

    // R6: each accepted input moves one stage per cycle.
    a_r6_stage_one: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> s1_q.valid);
    a_r6_stage_two: assert property (@(posedge clk) disable iff (!rst_n)
        s1_q.valid |=> out_valid);
    a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_q.valid |=> !out_valid);
    // R7: word is frozen when no result arrives.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !s1_q.valid |=> $stable(out_word));
    // R2: output sign follows the input sign captured a cycle earlier.
    a_r2_sign: assert property (@(posedge clk) disable iff (!rst_n)
        s1_q.valid |=> out_word[31] == $past(s1_q.neg));
    // R4: the encoder never emits a denormal pattern.
    a_r4_no_denormal: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_word[30:23] == '0) |-> out_word[22:0] == '0);
endmodule

// File: tb/sim_fxf_encoder.sv
module sim_fxf_encoder;
    localparam int NV = 14;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_fix = '0;
    logic        out_valid;
    logic [31:0] out_word;
    logic [31:0] cls_word = '0;
    logic [2:0]  cls_kind;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fxf_encoder #(.INT_W(16), .FRAC_W(16)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_fix    (in_fix),
        .out_valid (out_valid),
        .out_word  (out_word),
        .cls_word  (cls_word),
        .cls_kind  (cls_kind)
    );

    // {input Q16.16, expected float}
    localparam logic [63:0] VEC [NV] = '{
        {32'h0019C000, 32'h41CE0000},  // R1 25.75
        {32'h00010000, 32'h3F800000},  // R1 1.0
        {32'h00000001, 32'h37800000},  // R1 2^-16
        {32'h00030000, 32'h40400000},  // R1 3.0
        {32'h00008000, 32'h3F000000},  // R1 0.5
        {32'hFFFF0000, 32'hBF800000},  // R2 -1.0
        {32'hFFE64000, 32'hC1CE0000},  // R2 -25.75
        {32'h80000000, 32'hC7000000},  // R3 most negative
        {32'h00000000, 32'h00000000},  // R4 zero
        {32'h40000040, 32'h46800000},  // R5 tie, even stays
        {32'h400000C0, 32'h46800002},  // R5 tie, odd rounds up
        {32'h40000041, 32'h46800001},  // R5 above half
        {32'h4000003F, 32'h46800000},  // R5 below half
        {32'h7FFFFFFF, 32'h47000000}   // R5 carry into exponent
    };
    string vreq [NV] = '{"R1","R1","R1","R1","R1","R2","R2","R3","R4",
                         "R5","R5","R5","R5","R5"};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_cls(input logic [31:0] w, input logic [2:0] exp);
        @(negedge clk);
        cls_word = w;
        #1;
        chk("R8", {29'd0, cls_kind}, {29'd0, exp});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R9", {31'd0, out_valid}, 32'd0);
        chk("R9", out_word, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            in_valid = 1'b1;
            in_fix   = VEC[i][63:32];
            @(negedge clk);
            in_valid = 1'b0;
            in_fix   = 32'h12345678;
            chk("R6", {31'd0, out_valid}, 32'd0);
            @(negedge clk);
            chk("R6", {31'd0, out_valid}, 32'd1);
            chk(vreq[i], out_word, VEC[i][31:0]);
            in_fix = 32'h00050000;
            @(negedge clk);
            chk("R6", {31'd0, out_valid}, 32'd0);
            chk("R7", out_word, VEC[i][31:0]);
        end

        // R6: back-to-back conversions keep order.
        in_valid = 1'b1;
        in_fix   = 32'h00010000;
        @(negedge clk);
        in_fix   = 32'hFFE64000;
        @(negedge clk);
        in_valid = 1'b0;
        in_fix   = 32'h0;
        chk("R6", {31'd0, out_valid}, 32'd1);
        chk("R6", out_word, 32'h3F800000);
        @(negedge clk);
        chk("R6", {31'd0, out_valid}, 32'd1);
        chk("R6", out_word, 32'hC1CE0000);

        // R7: many idle cycles with changing input leave the word alone.
        for (int k = 0; k < 5; k++) begin
            in_fix = 32'h00001000 * (k + 1);
            @(negedge clk);
        end
        chk("R7", out_word, 32'hC1CE0000);
        chk("R7", {31'd0, out_valid}, 32'd0);

        // R8 classifier
        chk_cls(32'h00000000, 3'd0);
        chk_cls(32'h80000000, 3'd0);
        chk_cls(32'h00000001, 3'd1);
        chk_cls(32'h807FFFFF, 3'd1);
        chk_cls(32'h3F800000, 3'd2);
        chk_cls(32'h00800000, 3'd2);
        chk_cls(32'h7F7FFFFF, 3'd2);
        chk_cls(32'h7F800000, 3'd3);
        chk_cls(32'hFF800000, 3'd3);
        chk_cls(32'h7FC00000, 3'd4);
        chk_cls(32'h7F800001, 3'd4);

        // R9: reset in mid-stream clears the outputs.
        in_valid = 1'b1;
        in_fix   = 32'h00010000;
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);
        chk("R9", {31'd0, out_valid}, 32'd0);
        chk("R9", out_word, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9", {31'd0, out_valid}, 32'd0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule